// File: doc/BRIEF.md
# Protected Address Translation Cache

This block is a fully associative cache of page translations. It sits between a requester that issues 32-bit virtual addresses and the memory system, which sees 28-bit physical addresses. Pages are 4 KiB. The low 12 bits of an address pass through unchanged. The upper 20 bits are the page number: they are compared against every stored entry, and the matching entry supplies a 16-bit physical frame number. A lookup presents the address together with a write flag. One cycle later the block returns one of three results: a translated address, a miss exception, or a write-protection exception.

Each entry holds the following fields:

- a page tag
- a frame number
- a valid bit
- a dirty bit
- a reference bit
- a write-permission bit

A successful hit sets the entry's reference bit. A permitted write also sets its dirty bit. The response reports the dirty bit the entry held before the access, so the requester can tell that a page becomes dirty for the first time. After a miss, a walker or trap handler installs an entry through a refill port. The victim is chosen in this order: an entry holding the same tag, then a free entry, then an entry whose reference bit is clear, then a rotating pointer. A privileged flush clears the whole array. A separate pulse clears every reference bit, for periodic ageing.

Top module: `xlat_cache`

## Requirements
- R1: A request sampled on a clock edge produces `rsp_valid_o`=1 after that edge. On a permitted hit, `paddr_o` = {frame number of the matching entry, `vaddr_i[11:0]`}. When there is no request, `rsp_valid_o`, `miss_o` and `wprot_o` are 0 after the edge.
- R2: A request whose page number (`vaddr_i[31:12]`) matches no valid entry returns `miss_o`=1, `wprot_o`=0 and `paddr_o`=0.
- R3: A write request (`write_i`=1) that hits an entry with write permission clear returns `wprot_o`=1, `miss_o`=0 and `paddr_o`=0. A read of the same entry completes normally.
- R4: A write that hits a writable entry sets that entry's dirty bit. `dirty_o` reports the entry's dirty bit as it was before the access, so a first write returns 0 and any later access returns 1.
- R5: Any hit sets the entry's reference bit. A pulse on `ref_clear_i` clears all reference bits on the next edge.
- R6: A refill whose tag matches a valid entry overwrites that entry in place. The new frame number, the new permission, dirty=0 and reference=0 take effect, and no duplicate is created.
- R7: Otherwise, a refill goes to the lowest-index invalid entry.
- R8: If every entry is valid, the refill replaces the lowest-index entry whose reference bit is clear.
- R9: If every entry is valid and referenced, a round-robin pointer selects the victim. The pointer starts at index 0 after reset and advances by one, wrapping, each time it is used.
- R10: `flush_i` invalidates all entries on the next edge. When `flush_i` and `fill_i` are both high, the flush wins and no entry is installed.
- R11: `miss_o` and `wprot_o` are never both 1. If several entries match, the lowest index supplies the translation.
- R12: After reset all entries are invalid, the round-robin pointer is 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Lookup request |
| write_i | input | 1 | Lookup is a write |
| vaddr_i | input | 32 | Virtual address |
| rsp_valid_o | output | 1 | Registered response valid |
| paddr_o | output | 28 | Translated physical address, 0 on exception |
| miss_o | output | 1 | Miss exception |
| wprot_o | output | 1 | Write-protection exception |
| dirty_o | output | 1 | Dirty bit of the hit entry before this access |
| fill_i | input | 1 | Install an entry |
| fill_vpn_i | input | 20 | Page tag to install |
| fill_ppn_i | input | 16 | Frame number to install |
| fill_wr_ok_i | input | 1 | Write permission of the installed entry |
| flush_i | input | 1 | Invalidate all entries (privileged) |
| ref_clear_i | input | 1 | Clear all reference bits |

## Verification
The bench builds the block with the default 16 entries, which is small enough to fill completely with directed refills. A full array brings each victim rule within reach: the reference-clear rule, the round-robin rule with its pointer advancing from 0 to 1, and the fall-back to the lowest unreferenced entry after an ageing pulse. These rules are observed purely through which page numbers later miss. Dirty and reference state are observed through `dirty_o` and through eviction order, never from inside the design.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 28;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic             refd;
    logic             wr_ok;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } xlat_entry_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N  = 16,
  parameter int KW = 20,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][KW-1:0] tag_i,
  input  logic [KW-1:0]        key_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (eq[i]) idx_o = IW'(i);
  end
  assign hit_o = |eq;

  always_comb begin
    if (hit_o) begin
      a_r11_lowest_match: assert (eq[idx_o]);
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  ref_i,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o,
  output logic          use_rr_o
);
  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx, cold_idx;
  logic          any_free, any_cold;

  always_comb begin
    free_idx = '0;
    cold_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IW'(i);
      if (!ref_i[i])   cold_idx = IW'(i);
    end
  end
  assign any_free = ~&valid_i;
  assign any_cold = ~&ref_i;

  always_comb begin
    use_rr_o = 1'b0;
    if (any_free)      idx_o = free_idx;
    else if (any_cold) idx_o = cold_idx;
    else begin
      idx_o    = rr_q;
      use_rr_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rr_q <= '0;
    else if (adv_i && use_rr_o)      rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  a_r7_prefer_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_free |-> !valid_i[idx_o]);
  a_r8_prefer_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_free && any_cold) |-> !ref_i[idx_o]);
  a_r9_rr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && use_rr_o && rr_q != IW'(N - 1)) |=> rr_q == $past(rr_q) + 1'b1);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             write_i,
  input  logic [VA_W-1:0]  vaddr_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             miss_o,
  output logic             wprot_o,
  output logic             dirty_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_wr_ok_i,
  input  logic             flush_i,
  input  logic             ref_clear_i
);
  xlat_entry_t [NUM_ENTRIES-1:0] ents_q, ents_d;

  logic [NUM_ENTRIES-1:0]            valid_vec, ref_vec;
  logic [NUM_ENTRIES-1:0][VPN_W-1:0] vpn_vec;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      valid_vec[i] = ents_q[i].valid;
      ref_vec[i]   = ents_q[i].refd;
      vpn_vec[i]   = ents_q[i].vpn;
    end
  end

  // lookup
  logic          lk_hit;
  logic [IW-1:0] lk_idx;
  xlat_entry_t   lk_ent;
  logic          lk_deny;

  xlat_match #(.N(NUM_ENTRIES), .KW(VPN_W)) u_lk_match (
    .valid_i (valid_vec),
    .tag_i   (vpn_vec),
    .key_i   (vaddr_i[VA_W-1:OFF_W]),
    .hit_o   (lk_hit),
    .idx_o   (lk_idx)
  );

  assign lk_ent  = ents_q[lk_idx];
  assign lk_deny = write_i && !lk_ent.wr_ok;

  // refill target
  logic          dup_hit, use_rr;
  logic [IW-1:0] dup_idx, vic_idx, fill_idx;

  xlat_match #(.N(NUM_ENTRIES), .KW(VPN_W)) u_fill_match (
    .valid_i (valid_vec),
    .tag_i   (vpn_vec),
    .key_i   (fill_vpn_i),
    .hit_o   (dup_hit),
    .idx_o   (dup_idx)
  );

  xlat_victim #(.N(NUM_ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_vec),
    .ref_i    (ref_vec),
    .adv_i    (fill_i && !flush_i && !dup_hit),
    .idx_o    (vic_idx),
    .use_rr_o (use_rr)
  );

  assign fill_idx = dup_hit ? dup_idx : vic_idx;

  // next state: ageing, then hit status, then refill; flush overrides all
  always_comb begin
    ents_d = ents_q;
    if (ref_clear_i)
      for (int i = 0; i < NUM_ENTRIES; i++) ents_d[i].refd = 1'b0;
    if (req_i && lk_hit) begin
      ents_d[lk_idx].refd = 1'b1;
      if (write_i && lk_ent.wr_ok) ents_d[lk_idx].dirty = 1'b1;
    end
    if (fill_i) begin
      ents_d[fill_idx].valid = 1'b1;
      ents_d[fill_idx].dirty = 1'b0;
      ents_d[fill_idx].refd  = 1'b0;
      ents_d[fill_idx].wr_ok = fill_wr_ok_i;
      ents_d[fill_idx].vpn   = fill_vpn_i;
      ents_d[fill_idx].ppn   = fill_ppn_i;
    end
    if (flush_i) ents_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ents_q <= '0;
    else         ents_q <= ents_d;
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      miss_o      <= 1'b0;
      wprot_o     <= 1'b0;
      dirty_o     <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      miss_o      <= req_i && !lk_hit;
      wprot_o     <= req_i && lk_hit && lk_deny;
      dirty_o     <= req_i && lk_hit && lk_ent.dirty;
      paddr_o     <= (req_i && lk_hit && !lk_deny) ?
                     {lk_ent.ppn, vaddr_i[OFF_W-1:0]} : '0;
    end
  end

  a_r11_excl_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miss_o && wprot_o));
  a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && !miss_o && !wprot_o);
  a_r2_miss_no_pa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> paddr_o == '0);
  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_vec == '0);
  a_r4_dirty_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && write_i && lk_hit && lk_ent.wr_ok && !flush_i && !fill_i)
    |=> ents_q[$past(lk_idx)].dirty);
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [31:0] va = '0;
  logic        rsp_valid, miss, wprot, dirty;
  logic [27:0] pa;
  logic        fill = 1'b0, fill_wr_ok = 1'b0, flush = 1'b0, ref_clear = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [15:0] fill_ppn = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  xlat_cache #(.NUM_ENTRIES(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .write_i(wr), .vaddr_i(va),
    .rsp_valid_o(rsp_valid), .paddr_o(pa), .miss_o(miss), .wprot_o(wprot),
    .dirty_o(dirty), .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_wr_ok_i(fill_wr_ok), .flush_i(flush), .ref_clear_i(ref_clear)
  );

  task automatic chk(string req_tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req_tag, got, exp);
    end
  endtask

  task automatic lookup(logic [31:0] a, logic w);
    @(negedge clk);
    req = 1'b1; wr = w; va = a;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic refill(logic [19:0] vpn, logic [15:0] ppn, logic ok);
    @(negedge clk);
    fill = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = ok;
    @(negedge clk);
    fill = 1'b0;
  endtask

  task automatic expect_hit(string t, logic [31:0] a, logic [27:0] exp_pa);
    lookup(a, 1'b0);
    chk(t, {rsp_valid, miss, wprot}, 32'b100);
    chk(t, {4'h0, pa}, {4'h0, exp_pa});
  endtask

  task automatic expect_miss(string t, logic [31:0] a);
    lookup(a, 1'b0);
    chk(t, {rsp_valid, miss, wprot}, 32'b110);
    chk(t, {4'h0, pa}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R12 reset", {rsp_valid, miss, wprot, dirty}, 32'h0);
    chk("R12 reset pa", {4'h0, pa}, 32'h0);
    expect_miss("R12 empty after reset", 32'hC000_1560);
  endtask

  task automatic t_translate;
    refill(20'hC0001, 16'hA200, 1'b0);
    expect_hit("R1 translate", 32'hC000_1560, 28'hA200560);
    expect_miss("R2 miss", 32'hC000_6123);
    @(negedge clk);
    chk("R1 idle", {rsp_valid, miss, wprot}, 32'h0);
    lookup(32'hC000_1560, 1'b1);
    chk("R3 wprot", {rsp_valid, miss, wprot}, 32'b101);
    chk("R3 wprot pa", {4'h0, pa}, 32'h0);
  endtask

  task automatic t_dirty;
    refill(20'hC0006, 16'hF5C0, 1'b1);
    lookup(32'hC000_6123, 1'b1);
    chk("R4 first write", {wprot, dirty, 4'h0, pa}, {2'b00, 4'h0, 28'hF5C0123});
    lookup(32'hC000_6124, 1'b1);
    chk("R4 second write dirty", {31'h0, dirty}, 32'h1);
    lookup(32'hC000_6000, 1'b0);
    chk("R4 read sees dirty", {31'h0, dirty}, 32'h1);
    refill(20'hC0006, 16'h7290, 1'b1);
    lookup(32'hC000_6ABC, 1'b0);
    chk("R6 overwrite in place", {dirty, 3'h0, pa}, {1'b0, 3'h0, 28'h7290ABC});
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_miss("R10 flush", 32'hC000_1560);
    @(negedge clk);
    flush = 1'b1; fill = 1'b1; fill_vpn = 20'h12345; fill_ppn = 16'h1111; fill_wr_ok = 1'b1;
    @(negedge clk);
    flush = 1'b0; fill = 1'b0;
    expect_miss("R10 flush beats refill", 32'h1234_5000);
  endtask

  task automatic t_replace;
    for (int i = 0; i < 16; i++) refill(20'h00100 + 20'(i), 16'h1000 + 16'(i), 1'b0);
    for (int i = 0; i < 16; i++)
      if (i != 5) expect_hit("R7 filled free slots", 32'h0010_0000 + 32'(i) * 32'h1000,
                             28'h1000000 + 28'(i) * 28'h1000);
    refill(20'h0AAAA, 16'hAAAA, 1'b0);
    expect_miss("R8 unreferenced evicted", 32'h0010_5000);
    expect_hit("R8 new entry", 32'h0AAA_A000, 28'hAAAA000);
    refill(20'h0BBBB, 16'hBBBB, 1'b0);
    expect_miss("R9 rr picks index 0", 32'h0010_0000);
    expect_hit("R9 new entry", 32'h0BBB_B000, 28'hBBBB000);
    refill(20'h0CCCC, 16'hCCCC, 1'b0);
    expect_miss("R9 rr advanced to 1", 32'h0010_1000);
    expect_hit("R9 survivor", 32'h0010_3000, 28'h1003000);
  endtask

  task automatic t_age;
    @(negedge clk); ref_clear = 1'b1;
    @(negedge clk); ref_clear = 1'b0;
    refill(20'h0DDDD, 16'hDDDD, 1'b0);
    expect_miss("R5 clear then lowest cold", 32'h0BBB_B000);
    expect_hit("R5 other kept", 32'h0010_2000, 28'h1002000);
    expect_hit("R5 new entry", 32'h0DDD_D000, 28'hDDDD000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_dirty();
    t_flush();
    t_replace();
    t_age();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule